// File: doc/BRIEF.md
# Length-Prefixed Packet Receiver with CRC-16

This block sits behind a serial word receiver and turns a stream of 8-bit words, one per valid strobe, into checked packets. A packet opens with a start code. The next word gives the payload length. The payload words follow, and two check bytes close the packet. Each payload word goes straight out of a write port into an external receive buffer, at consecutive addresses. After the last check byte the block compares the received CRC with the one it computed, then raises either a frame-received flag or a frame-error flag.

The upper layer reads the buffer when the received flag is up and then pulses an acknowledge to release it. A new start code is ignored until that acknowledge arrives, so a frame that has not been read is never overwritten. The error flag covers two cases: a check-byte mismatch, and a payload word that the buffer cannot take. The buffer cannot take a word when it signals not ready or when the word would fall past its depth.

Top module: `pkt_rx_top`

## Requirements
- R1: A packet consists of the start code (parameter, default 0xA5), one length word m (0..255), m payload words, then the CRC high byte and then the CRC low byte, for m+4 words in total.
- R2: Payload word i (counting from 0) appears on the write port with wrEn high, wrAddr = i and wrData = the word, in the same cycle as its strobe.
- R3: The CRC uses polynomial 0x8005 (x16+x15+x2+1), starts at 0x0000, takes each word MSB first and covers the length word and the payload; there is no final inversion.
- R4: A start code seen in idle is ignored while frameOk is high: busy stays low and nothing is written.
- R5: Accepting a start code clears frameOk and frameErr and raises busy on the next cycle.
- R6: If the two CRC bytes match, frameOk is high and busy is low from the cycle after the low CRC byte.
- R7: If the CRC bytes do not match, frameErr rises, frameOk stays low and the block returns to idle.
- R8: A payload word that arrives while bufReady is low is not written; frameErr rises and the block returns to idle.
- R9: A payload word whose index is at or past BUF_DEPTH is not written; frameErr rises and the block returns to idle.
- R10: The block advances only on cycles with wordValid high. Gaps between words leave the result unchanged.
- R11: A frameAck pulse clears frameOk. If frameOk is being set in the same cycle, setting wins.
- R12: A length word of 0 leads straight to the CRC bytes, with no writes.
- R13: Non-start words that arrive in idle are ignored.
- R14: A payload word equal to the start code is stored as ordinary data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wordValid | input | 1 | New-word strobe |
| wordIn | input | WORD_W | Received word |
| bufReady | input | 1 | Receive buffer can accept a word |
| frameAck | input | 1 | Upper layer has consumed the frame |
| wrEn | output | 1 | Buffer write strobe |
| wrAddr | output | ADDR_W | Buffer write address (payload index) |
| wrData | output | WORD_W | Buffer write data |
| rxLen | output | WORD_W | Latched payload length of the current or last frame |
| frameOk | output | 1 | Good frame received, waiting for acknowledge |
| frameErr | output | 1 | Last frame failed its CRC check or overran the buffer |
| busy | output | 1 | Frame reception in progress |

## Verification
The bench builds the block with BUF_DEPTH = 16 and keeps the default start code and word width. The small depth lets a 20-word payload run past the end of the buffer in a few dozen cycles, while a 16-word payload fills it exactly. A payload that begins with the start code, a zero-length frame, strobe gaps and a corrupted CRC are each run at this size. Every expected write is computed from a bench-side CRC model and queued for comparison.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEN,
    ST_PAY,
    ST_CRCH,
    ST_CRCL
  } rxState_t;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic clrCrc;
    logic loadLen;
    logic crcEn;
    logic writeEn;
    logic saveCrcHi;
  } rxCtrl_t;

endpackage

// File: rtl/pkt_rx_datapath.sv
module pkt_rx_datapath
  import pkt_rx_pkg::*;
#(
  parameter int WORD_W    = 8,
  parameter int BUF_DEPTH = 256,
  parameter logic [15:0] CRC_POLY = 16'h8005
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  rxCtrl_t                  ctl,
  input  logic [WORD_W-1:0]        wordIn,
  output logic [$clog2(BUF_DEPTH)-1:0] wrAddr,
  output logic [WORD_W-1:0]        lenOut,
  output logic                     lastPayload,
  output logic                     overrun,
  output logic                     crcMatch
);
  localparam int CNT_W  = WORD_W;
  localparam int ADDR_W = $clog2(BUF_DEPTH);

  logic [15:0]       crcReg;
  logic [WORD_W-1:0] crcHi;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] lenReg;

  function automatic logic [15:0] crcStep(input logic [15:0] c, input logic [WORD_W-1:0] d);
    logic [15:0] r;
    r = c;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      if (r[15] ^ d[i]) r = {r[14:0], 1'b0} ^ CRC_POLY;
      else              r = {r[14:0], 1'b0};
    end
    return r;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcReg <= '0;
      crcHi  <= '0;
      cnt    <= '0;
      lenReg <= '0;
    end else begin
      if (ctl.clrCrc)     crcReg <= '0;
      else if (ctl.crcEn) crcReg <= crcStep(crcReg, wordIn);
      if (ctl.loadLen) begin
        lenReg <= wordIn;
        cnt    <= '0;
      end else if (ctl.writeEn) begin
        cnt <= cnt + 1'b1;
      end
      if (ctl.saveCrcHi) crcHi <= wordIn;
    end
  end

  assign wrAddr      = cnt[ADDR_W-1:0];
  assign lenOut      = lenReg;
  assign lastPayload = (CNT_W'(cnt + 1'b1) == lenReg);
  assign overrun     = ({1'b0, cnt} >= (CNT_W + 1)'(BUF_DEPTH));
  assign crcMatch    = ({crcHi, wordIn} == crcReg);

  // R9: a write never happens past the buffer depth
  a_r9_no_overrun_write: assert property (@(posedge clk) disable iff (!rstN)
    ctl.writeEn |-> !overrun);
  // R2: write index stays within the announced length
  a_r2_index_in_len: assert property (@(posedge clk) disable iff (!rstN)
    ctl.writeEn |-> (cnt < lenReg));
  // R3: CRC register cleared at frame start
  a_r3_crc_cleared: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clrCrc |=> (crcReg == 16'h0000));

endmodule

// File: rtl/pkt_rx_ctrl.sv
module pkt_rx_ctrl
  import pkt_rx_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter logic [WORD_W-1:0] SOF_CODE = 8'hA5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wordValid,
  input  logic [WORD_W-1:0] wordIn,
  input  logic              bufReady,
  input  logic              frameAck,
  input  logic              lastPayload,
  input  logic              overrun,
  input  logic              crcMatch,
  output rxCtrl_t           ctl,
  output logic              frameOk,
  output logic              frameErr,
  output logic              busy
);
  rxState_t state, nextState;
  logic startFrame, setOk, setErr;

  always_comb begin
    nextState  = state;
    ctl        = '0;
    startFrame = 1'b0;
    setOk      = 1'b0;
    setErr     = 1'b0;
    if (wordValid) begin
      unique case (state)
        ST_IDLE: if (wordIn == SOF_CODE && !frameOk) begin
          startFrame = 1'b1;
          ctl.clrCrc = 1'b1;
          nextState  = ST_LEN;
        end
        ST_LEN: begin
          ctl.loadLen = 1'b1;
          ctl.crcEn   = 1'b1;
          nextState   = (wordIn == '0) ? ST_CRCH : ST_PAY;
        end
        ST_PAY: begin
          if (overrun || !bufReady) begin
            setErr    = 1'b1;
            nextState = ST_IDLE;
          end else begin
            ctl.writeEn = 1'b1;
            ctl.crcEn   = 1'b1;
            if (lastPayload) nextState = ST_CRCH;
          end
        end
        ST_CRCH: begin
          ctl.saveCrcHi = 1'b1;
          nextState     = ST_CRCL;
        end
        ST_CRCL: begin
          if (crcMatch) setOk = 1'b1;
          else          setErr = 1'b1;
          nextState = ST_IDLE;
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      frameOk  <= 1'b0;
      frameErr <= 1'b0;
    end else begin
      state <= nextState;
      if (startFrame) begin
        frameOk  <= 1'b0;
        frameErr <= 1'b0;
      end else begin
        if (setOk)         frameOk <= 1'b1;
        else if (frameAck) frameOk <= 1'b0;
        if (setErr)        frameErr <= 1'b1;
      end
    end
  end

  assign busy = (state != ST_IDLE);

  // R4: start code refused while a frame waits for acknowledge
  a_r4_start_blocked: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && wordValid && wordIn == SOF_CODE && frameOk) |=> (state == ST_IDLE));
  // R10: no strobe, no progress
  a_r10_hold_state: assert property (@(posedge clk) disable iff (!rstN)
    !wordValid |=> $stable(state));
  // R7: received and error flags never both set
  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(frameOk && frameErr));
  // R8: buffer not ready on a payload word aborts with error
  a_r8_not_ready_abort: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PAY && wordValid && !bufReady) |=> (frameErr && state == ST_IDLE));
  // R5: accepted start clears both flags
  a_r5_start_clears: assert property (@(posedge clk) disable iff (!rstN)
    startFrame |=> (!frameOk && !frameErr && busy));

endmodule

// File: rtl/pkt_rx_top.sv
module pkt_rx_top
  import pkt_rx_pkg::*;
#(
  parameter int WORD_W    = 8,
  parameter int BUF_DEPTH = 256,
  parameter logic [WORD_W-1:0] SOF_CODE = 8'hA5,
  localparam int ADDR_W = $clog2(BUF_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wordValid,
  input  logic [WORD_W-1:0] wordIn,
  input  logic              bufReady,
  input  logic              frameAck,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] rxLen,
  output logic              frameOk,
  output logic              frameErr,
  output logic              busy
);
  rxCtrl_t ctl;
  logic lastPayload, overrun, crcMatch;

  pkt_rx_ctrl #(.WORD_W(WORD_W), .SOF_CODE(SOF_CODE)) uCtrl (
    .clk(clk), .rstN(rstN), .wordValid(wordValid), .wordIn(wordIn),
    .bufReady(bufReady), .frameAck(frameAck), .lastPayload(lastPayload),
    .overrun(overrun), .crcMatch(crcMatch), .ctl(ctl),
    .frameOk(frameOk), .frameErr(frameErr), .busy(busy)
  );

  pkt_rx_datapath #(.WORD_W(WORD_W), .BUF_DEPTH(BUF_DEPTH)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wordIn(wordIn), .wrAddr(wrAddr),
    .lenOut(rxLen), .lastPayload(lastPayload), .overrun(overrun),
    .crcMatch(crcMatch)
  );

  assign wrEn   = ctl.writeEn;
  assign wrData = wordIn;

endmodule

// File: tb/tb_pkt_rx_top.sv
`timescale 1ns/1ps
module tb_pkt_rx_top;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);
  localparam logic [7:0] SOF = 8'hA5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wordValid = 1'b0;
  logic [7:0] wordIn = '0;
  logic bufReady = 1'b1;
  logic frameAck = 1'b0;
  logic wrEn, frameOk, frameErr, busy;
  logic [AW-1:0] wrAddr;
  logic [7:0] wrData, rxLen;

  int errors = 0;
  int checks = 0;
  int expQ[$];

  always #2 clk = ~clk;

  pkt_rx_top #(.WORD_W(8), .BUF_DEPTH(DEPTH), .SOF_CODE(SOF)) dut (
    .clk(clk), .rstN(rstN), .wordValid(wordValid), .wordIn(wordIn),
    .bufReady(bufReady), .frameAck(frameAck), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rxLen(rxLen), .frameOk(frameOk), .frameErr(frameErr),
    .busy(busy)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference CRC: augmented long division over message bits, then 16 zero bits
  function automatic logic [15:0] refCrc(input logic [7:0] msg[$]);
    logic [15:0] rem = '0;
    logic top;
    foreach (msg[k]) for (int b = 7; b >= 0; b--) begin
      top = rem[15];
      rem = {rem[14:0], msg[k][b]};
      if (top) rem = rem ^ 16'h8005;
    end
    for (int z = 0; z < 16; z++) begin
      top = rem[15];
      rem = {rem[14:0], 1'b0};
      if (top) rem = rem ^ 16'h8005;
    end
    return rem;
  endfunction

  // Scoreboard monitor: compares each buffer write with the queue
  initial forever begin
    @(negedge clk);
    #1;
    if (wrEn) begin
      if (expQ.size() == 0) chk("R2 unexpected write", {wrAddr, wrData}, 0);
      else chk("R2 write", int'({wrAddr, wrData}), expQ.pop_front());
    end
  end

  task automatic sendWord(input logic [7:0] w, input bit rdy, input bit gap);
    if (gap) begin
      @(negedge clk);
      wordValid = 1'b0;
    end
    @(negedge clk);
    wordValid = 1'b1;
    wordIn = w;
    bufReady = rdy;
  endtask

  task automatic idle();
    @(negedge clk);
    wordValid = 1'b0;
    bufReady = 1'b1;
    #1;
  endtask

  task automatic ack();
    @(negedge clk);
    frameAck = 1'b1;
    @(negedge clk);
    frameAck = 1'b0;
    #1;
    chk("R11 ack clears frameOk", frameOk, 0);
  endtask

  task automatic sendPacket(input int len, input logic [7:0] base, input bit badCrc,
                            input int dropAt, input bit gaps, input bit chkStart);
    logic [7:0] msg[$];
    logic [15:0] c;
    msg.push_back(len[7:0]);
    for (int i = 0; i < len; i++) msg.push_back(8'(base + i * 7));
    c = refCrc(msg);
    if (badCrc) c = c ^ 16'h0100;
    sendWord(SOF, 1'b1, gaps);
    if (chkStart) begin
      idle();
      chk("R5 busy after start", busy, 1);
      chk("R5 frameErr cleared", frameErr, 0);
    end
    sendWord(msg[0], 1'b1, gaps);
    for (int i = 0; i < len; i++) begin
      if (i == dropAt) begin
        sendWord(msg[i + 1], 1'b0, gaps);
        return;
      end
      if (i >= DEPTH) begin
        sendWord(msg[i + 1], 1'b1, gaps);
        return;
      end
      expQ.push_back(int'({AW'(i), msg[i + 1]}));
      sendWord(msg[i + 1], 1'b1, gaps);
    end
    sendWord(c[15:8], 1'b1, gaps);
    sendWord(c[7:0], 1'b1, gaps);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R6 reset frameOk", frameOk, 0);
    chk("R7 reset frameErr", frameErr, 0);
    chk("R10 reset busy", busy, 0);
    rstN = 1'b1;

    // R1 R2 R3 R6: good frame of 3 words
    sendPacket(3, 8'h10, 0, -1, 0, 0);
    idle();
    chk("R6 good frame ok", frameOk, 1);
    chk("R6 busy cleared", busy, 0);
    chk("R1 length latched", rxLen, 3);

    // R4: start code while frameOk set is ignored
    sendWord(SOF, 1'b1, 0);
    sendWord(8'h02, 1'b1, 0);
    sendWord(8'h11, 1'b1, 0);
    idle();
    chk("R4 start ignored busy", busy, 0);
    chk("R4 frameOk kept", frameOk, 1);
    ack();

    // R13: non-start words in idle
    sendWord(8'h00, 1'b1, 0);
    sendWord(8'h33, 1'b1, 0);
    idle();
    chk("R13 idle words ignored", busy, 0);

    // R12: zero-length frame
    sendPacket(0, 8'h00, 0, -1, 0, 0);
    idle();
    chk("R12 empty frame ok", frameOk, 1);
    ack();

    // R7: corrupted CRC
    sendPacket(4, 8'h40, 1, -1, 0, 0);
    idle();
    chk("R7 bad crc error", frameErr, 1);
    chk("R7 bad crc not ok", frameOk, 0);
    chk("R7 back to idle", busy, 0);

    // R5 R14: new start clears error; payload begins with start code
    sendPacket(5, SOF, 0, -1, 0, 1);
    idle();
    chk("R14 frame with start-code data ok", frameOk, 1);
    chk("R5 error stays clear", frameErr, 0);
    ack();

    // R8: buffer not ready at word 2
    sendPacket(6, 8'h21, 0, 2, 0, 0);
    idle();
    chk("R8 not ready error", frameErr, 1);
    chk("R8 back to idle", busy, 0);

    // R9: overrun past depth
    sendPacket(20, 8'h03, 0, -1, 0, 0);
    idle();
    chk("R9 overrun error", frameErr, 1);
    chk("R9 back to idle", busy, 0);

    // R9 boundary: exactly DEPTH words fit
    sendPacket(DEPTH, 8'h77, 0, -1, 0, 0);
    idle();
    chk("R9 full buffer ok", frameOk, 1);
    chk("R9 full buffer no error", frameErr, 0);
    ack();

    // R10: gaps between strobes
    sendPacket(7, 8'hC8, 0, -1, 1, 0);
    idle();
    chk("R10 gapped frame ok", frameOk, 1);
    ack();

    repeat (3) idle();
    chk("R2 all expected writes seen", expQ.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule